// File: doc/BRIEF.md
# Power-Aware Three-Client Memory Arbiter

This block sits between three request producers in a video decode pipeline and a memory controller. The producers are a motion-compensation reader, a look-ahead prefetch reader and a deblocking-filter writer. Each producer pushes quad-sized requests into its own small input FIFO. Each cycle the arbiter grants at most one request. The choice depends on urgency, on a read/write batching mode that keeps the bus from turning around often, and on a fixed fallback order.

Every granted request is shown on a cache snoop port one cycle after the grant. The same request is also queued in a pending-address FIFO. The head of that FIFO retires in order:

- A read waits for the matching hit/miss answer from the cache. A hit is dropped, and only a miss goes to memory.
- A write waits until quad data sits in the write buffer, and the data leaves together with the request.

The arbiter also drives a memory power-down request. Memory stays asleep until either client urgency rises. After urgency ends, a programmable idle countdown runs before memory sleeps again.

Top module: `mem_pwr_arb`

## Requirements
- R1: After reset, `mem_pd` is 1 (asleep), `snp_vld` and `mem_vld` are 0, `fl_urgent` is 0, and no grant happens while every client FIFO is empty.
- R2: Among non-empty clients, the grant order is as follows:
  1. The motion-compensation reader, if `mc_urgent` is high.
  2. The filter, if `fl_urgent` is high.
  3. In read mode, the motion-compensation reader, then the prefetcher.
  4. In write mode, the filter.
  5. Otherwise the motion-compensation reader, then the filter, then the prefetcher.
- R3: Reset leaves the arbiter in read mode with both run counters at 0.
  - Each read grant clears the write run count and adds one to the read run count. When the read count reaches `cfg_rd_max`, it returns to 0 and the mode becomes write.
  - Write grants work the same way against `cfg_wr_max` and switch the mode back to read.
  - The counters change only on a grant.
- R4: `fl_urgent` sets on the cycle after write-buffer occupancy is above `cfg_wm_hi`. It clears on the cycle after occupancy is below `cfg_wm_lo`. Between the two thresholds it holds its value.
- R5: While `mc_urgent` or `fl_urgent` is high, `mem_pd` goes to 0 on the next cycle and the idle counter reloads to `cfg_idle`. With no urgency, the counter counts down, and `mem_pd` returns to 1 exactly `cfg_idle` cycles after the last urgent cycle.
- R6: A grant shows on the snoop port on the next cycle. The snoop carries source code 0 for the filter, 1 for motion compensation and 2 for the prefetcher. It carries type 0 for a read and 1 for a write, plus the 40-bit address and the tag. Filter writes always carry tag 0.
- R7: A write at the pending head retires only when the write buffer is non-empty. It then issues one memory write that carries the oldest buffered quad.
- R8: A read at the pending head retires only when a cache answer is queued. `cr_hit` = 1 drops the read, and `cr_hit` = 0 issues it to memory with its source, address and tag.
- R9: Grants and snoops continue while `mem_pd` is 1. The pending head stalls, and no memory request is issued while memory is asleep.
- R10: A full pending-address FIFO blocks every grant. Freeing one slot lets exactly one more grant through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_push | input | 1 | Push a motion-compensation read |
| mc_addr | input | 40 | Motion-compensation read address |
| mc_tag | input | 4 | Motion-compensation read tag |
| mc_full | output | 1 | Motion-compensation FIFO full |
| mc_urgent | input | 1 | Motion compensator is low on data |
| pf_push | input | 1 | Push a prefetch read |
| pf_addr | input | 40 | Prefetch read address |
| pf_tag | input | 4 | Prefetch read tag |
| pf_full | output | 1 | Prefetch FIFO full |
| fl_push | input | 1 | Push a filter write |
| fl_addr | input | 40 | Filter write address |
| fl_full | output | 1 | Filter FIFO full |
| wd_push | input | 1 | Push one quad into the write buffer |
| wd_data | input | 32 | Write quad data |
| wd_full | output | 1 | Write buffer full |
| cr_vld | input | 1 | Cache answer valid for the oldest unanswered read snoop |
| cr_hit | input | 1 | Cache answer: 1 hit, 0 miss |
| cfg_rd_max | input | 4 | Read grants per read batch |
| cfg_wr_max | input | 4 | Write grants per write batch |
| cfg_wm_hi | input | 4 | Write-buffer high watermark |
| cfg_wm_lo | input | 4 | Write-buffer low watermark |
| cfg_idle | input | 16 | Idle cycles before power-down |
| snp_vld | output | 1 | Snoop valid |
| snp_src | output | 2 | Snoop source code |
| snp_type | output | 1 | Snoop type (1 = write) |
| snp_addr | output | 40 | Snoop address |
| snp_tag | output | 4 | Snoop tag |
| mem_vld | output | 1 | Memory request valid |
| mem_src | output | 2 | Memory request source code |
| mem_type | output | 1 | Memory request type (1 = write) |
| mem_addr | output | 40 | Memory request address |
| mem_tag | output | 4 | Memory request tag |
| mem_wdata | output | 32 | Write data for a memory write |
| mem_pd | output | 1 | Memory power-down request |
| fl_urgent | output | 1 | Filter urgency flag |

## Verification
The bench fills all three client FIFOs at once and checks the exact snoop order. An arbiter that miscounts batches, or that switches mode on cycles with no grant, would interleave reads and writes in a different order. Urgency cases check two overrides: an urgent filter must beat read mode, and an urgent motion compensator must beat an urgent filter. They also walk the write-buffer occupancy down through the hysteresis band, which catches a flag that clears at the high threshold.

The drain cases cover four faults:
- A read issued before its cache answer arrives.
- A cache hit that is still sent to memory.
- A write sent without data.
- Any request that leaves while memory is asleep.

The power-down countdown is checked on the exact cycle, which catches an off-by-one in the idle counter. The full pending FIFO case confirms that exactly one extra grant follows a single retirement.

// File: rtl/mem_pwr_arb_pkg.sv
package mem_pwr_arb_pkg;
  localparam logic [1:0] SRC_FL = 2'd0;
  localparam logic [1:0] SRC_MC = 2'd1;
  localparam logic [1:0] SRC_PF = 2'd2;

  typedef enum logic {
    MODE_RD = 1'b0,
    MODE_WR = 1'b1
  } bat_mode_e;
endpackage

// File: rtl/arb_fifo.sv
module arb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic [WIDTH-1:0]               din,
  input  logic                           pop,
  output logic [WIDTH-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |-> !full);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/arb_select.sv
module arb_select import mem_pwr_arb_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_mc,
  input  logic             req_pf,
  input  logic             req_fl,
  input  logic             urg_mc,
  input  logic             urg_fl,
  input  logic             pend_full,
  input  logic [CNT_W-1:0] cfg_rd_max,
  input  logic [CNT_W-1:0] cfg_wr_max,
  output logic             gnt_mc,
  output logic             gnt_pf,
  output logic             gnt_fl
);
  bat_mode_e        mode_q;
  logic [CNT_W-1:0] rd_cnt_q, wr_cnt_q, rd_nxt, wr_nxt;

  assign rd_nxt = rd_cnt_q + CNT_W'(1);
  assign wr_nxt = wr_cnt_q + CNT_W'(1);

  always_comb begin
    gnt_mc = 1'b0;
    gnt_pf = 1'b0;
    gnt_fl = 1'b0;
    if (!pend_full) begin
      if (urg_mc && req_mc)                  gnt_mc = 1'b1;
      else if (urg_fl && req_fl)             gnt_fl = 1'b1;
      else if (mode_q == MODE_RD && req_mc)  gnt_mc = 1'b1;
      else if (mode_q == MODE_RD && req_pf)  gnt_pf = 1'b1;
      else if (mode_q == MODE_WR && req_fl)  gnt_fl = 1'b1;
      else if (req_mc)                       gnt_mc = 1'b1;
      else if (req_fl)                       gnt_fl = 1'b1;
      else if (req_pf)                       gnt_pf = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_RD;
      rd_cnt_q <= '0;
      wr_cnt_q <= '0;
    end else if (gnt_mc || gnt_pf) begin
      wr_cnt_q <= '0;
      if (rd_nxt >= cfg_rd_max) begin
        rd_cnt_q <= '0;
        mode_q   <= MODE_WR;
      end else begin
        rd_cnt_q <= rd_nxt;
        mode_q   <= MODE_RD;
      end
    end else if (gnt_fl) begin
      rd_cnt_q <= '0;
      if (wr_nxt >= cfg_wr_max) begin
        wr_cnt_q <= '0;
        mode_q   <= MODE_RD;
      end else begin
        wr_cnt_q <= wr_nxt;
        mode_q   <= MODE_WR;
      end
    end
  end

  // R3
  rd_to_wr_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt_mc || gnt_pf) && (rd_cnt_q + CNT_W'(1) >= cfg_rd_max)) |=> (mode_q == MODE_WR));

  // R3
  wr_to_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_fl && (wr_cnt_q + CNT_W'(1) >= cfg_wr_max)) |=> (mode_q == MODE_RD));
endmodule

// File: rtl/arb_pwr_ctl.sv
module arb_pwr_ctl #(
  parameter int OCC_W  = 4,
  parameter int IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_urgent,
  input  logic [OCC_W-1:0]  wbuf_occ,
  input  logic [OCC_W-1:0]  cfg_hi,
  input  logic [OCC_W-1:0]  cfg_lo,
  input  logic [IDLE_W-1:0] cfg_idle,
  output logic              fl_urgent,
  output logic              mem_pd
);
  logic              fl_urg_q, pd_q, urg_any;
  logic [IDLE_W-1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst)                    fl_urg_q <= 1'b0;
    else if (wbuf_occ > cfg_hi) fl_urg_q <= 1'b1;
    else if (wbuf_occ < cfg_lo) fl_urg_q <= 1'b0;
  end

  assign urg_any = mc_urgent | fl_urg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_q   <= 1'b1;
      idle_q <= '0;
    end else if (urg_any) begin
      pd_q   <= 1'b0;
      idle_q <= cfg_idle;
    end else if (idle_q != '0) begin
      idle_q <= idle_q - IDLE_W'(1);
      if (idle_q == IDLE_W'(1)) pd_q <= 1'b1;
    end else begin
      pd_q <= 1'b1;
    end
  end

  assign fl_urgent = fl_urg_q;
  assign mem_pd    = pd_q;

  // R5
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    urg_any |=> !pd_q);

  // R5
  sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (!urg_any && idle_q == IDLE_W'(1)) |=> pd_q);

  // R4
  urg_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wbuf_occ > cfg_hi) |=> fl_urg_q);

  // R4
  urg_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wbuf_occ < cfg_lo && !(wbuf_occ > cfg_hi)) |=> !fl_urg_q);
endmodule

// File: rtl/mem_pwr_arb.sv
module mem_pwr_arb import mem_pwr_arb_pkg::*; #(
  parameter int ADDR_W      = 40,
  parameter int TAG_W       = 4,
  parameter int DATA_W      = 32,
  parameter int CFIFO_DEPTH = 4,
  parameter int PEND_DEPTH  = 8,
  parameter int WBUF_DEPTH  = 8,
  parameter int RESP_DEPTH  = 8,
  parameter int CNT_W       = 4,
  parameter int IDLE_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  mc_push,
  input  logic [ADDR_W-1:0]                     mc_addr,
  input  logic [TAG_W-1:0]                      mc_tag,
  output logic                                  mc_full,
  input  logic                                  mc_urgent,
  input  logic                                  pf_push,
  input  logic [ADDR_W-1:0]                     pf_addr,
  input  logic [TAG_W-1:0]                      pf_tag,
  output logic                                  pf_full,
  input  logic                                  fl_push,
  input  logic [ADDR_W-1:0]                     fl_addr,
  output logic                                  fl_full,
  input  logic                                  wd_push,
  input  logic [DATA_W-1:0]                     wd_data,
  output logic                                  wd_full,
  input  logic                                  cr_vld,
  input  logic                                  cr_hit,
  input  logic [CNT_W-1:0]                      cfg_rd_max,
  input  logic [CNT_W-1:0]                      cfg_wr_max,
  input  logic [$clog2(WBUF_DEPTH+1)-1:0]       cfg_wm_hi,
  input  logic [$clog2(WBUF_DEPTH+1)-1:0]       cfg_wm_lo,
  input  logic [IDLE_W-1:0]                     cfg_idle,
  output logic                                  snp_vld,
  output logic [1:0]                            snp_src,
  output logic                                  snp_type,
  output logic [ADDR_W-1:0]                     snp_addr,
  output logic [TAG_W-1:0]                      snp_tag,
  output logic                                  mem_vld,
  output logic [1:0]                            mem_src,
  output logic                                  mem_type,
  output logic [ADDR_W-1:0]                     mem_addr,
  output logic [TAG_W-1:0]                      mem_tag,
  output logic [DATA_W-1:0]                     mem_wdata,
  output logic                                  mem_pd,
  output logic                                  fl_urgent
);
  localparam int NCL   = 3;
  localparam int ENT_W = ADDR_W + TAG_W;
  localparam int REQ_W = 2 + 1 + ENT_W;
  localparam int CCW   = $clog2(CFIFO_DEPTH + 1);
  localparam int PCW   = $clog2(PEND_DEPTH + 1);
  localparam int OCC_W = $clog2(WBUF_DEPTH + 1);
  localparam int RCW   = $clog2(RESP_DEPTH + 1);

  // client index 0 filter, 1 motion compensation, 2 prefetch
  logic             cl_push [NCL];
  logic             cl_pop  [NCL];
  logic [ENT_W-1:0] cl_din  [NCL];
  logic [ENT_W-1:0] cl_dout [NCL];
  logic [CCW-1:0]   cl_cnt  [NCL];
  logic             cl_req  [NCL];

  assign cl_push[0] = fl_push;
  assign cl_push[1] = mc_push;
  assign cl_push[2] = pf_push;
  assign cl_din[0]  = {fl_addr, TAG_W'(0)};
  assign cl_din[1]  = {mc_addr, mc_tag};
  assign cl_din[2]  = {pf_addr, pf_tag};

  for (genvar g = 0; g < NCL; g++) begin : g_client
    arb_fifo #(.WIDTH(ENT_W), .DEPTH(CFIFO_DEPTH)) u_cfifo (
      .clk(clk), .rst(rst), .push(cl_push[g]), .din(cl_din[g]),
      .pop(cl_pop[g]), .dout(cl_dout[g]), .count(cl_cnt[g]));
    assign cl_req[g] = (cl_cnt[g] != '0);
  end

  assign fl_full = (cl_cnt[0] == CCW'(CFIFO_DEPTH));
  assign mc_full = (cl_cnt[1] == CCW'(CFIFO_DEPTH));
  assign pf_full = (cl_cnt[2] == CCW'(CFIFO_DEPTH));

  // power and urgency
  logic [OCC_W-1:0] wbuf_cnt;
  logic             pd_w, fl_urg_w;

  arb_pwr_ctl #(.OCC_W(OCC_W), .IDLE_W(IDLE_W)) u_pwr (
    .clk(clk), .rst(rst), .mc_urgent(mc_urgent), .wbuf_occ(wbuf_cnt),
    .cfg_hi(cfg_wm_hi), .cfg_lo(cfg_wm_lo), .cfg_idle(cfg_idle),
    .fl_urgent(fl_urg_w), .mem_pd(pd_w));

  assign mem_pd    = pd_w;
  assign fl_urgent = fl_urg_w;

  // selection
  logic [PCW-1:0] pend_cnt;
  logic           pend_full, pend_empty;
  logic           gnt_mc, gnt_pf, gnt_fl, any_gnt;

  assign pend_full  = (pend_cnt == PCW'(PEND_DEPTH));
  assign pend_empty = (pend_cnt == '0);

  arb_select #(.CNT_W(CNT_W)) u_sel (
    .clk(clk), .rst(rst), .req_mc(cl_req[1]), .req_pf(cl_req[2]),
    .req_fl(cl_req[0]), .urg_mc(mc_urgent), .urg_fl(fl_urg_w),
    .pend_full(pend_full), .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max),
    .gnt_mc(gnt_mc), .gnt_pf(gnt_pf), .gnt_fl(gnt_fl));

  assign cl_pop[0] = gnt_fl;
  assign cl_pop[1] = gnt_mc;
  assign cl_pop[2] = gnt_pf;
  assign any_gnt   = gnt_mc | gnt_pf | gnt_fl;

  logic [1:0]       win_src;
  logic             win_type;
  logic [ENT_W-1:0] win_ent;

  always_comb begin
    win_src = SRC_FL;
    win_ent = cl_dout[0];
    if (gnt_mc) begin
      win_src = SRC_MC;
      win_ent = cl_dout[1];
    end else if (gnt_pf) begin
      win_src = SRC_PF;
      win_ent = cl_dout[2];
    end
  end
  assign win_type = (win_src == SRC_FL);

  // snoop port
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_vld  <= 1'b0;
      snp_src  <= '0;
      snp_type <= 1'b0;
      snp_addr <= '0;
      snp_tag  <= '0;
    end else begin
      snp_vld <= any_gnt;
      if (any_gnt) begin
        snp_src  <= win_src;
        snp_type <= win_type;
        snp_addr <= win_ent[ENT_W-1:TAG_W];
        snp_tag  <= win_ent[TAG_W-1:0];
      end
    end
  end

  // pending, write buffer, cache answer FIFOs
  logic [REQ_W-1:0]  pend_dout;
  logic              pend_pop;
  logic [DATA_W-1:0] wbuf_dout;
  logic              wbuf_pop;
  logic [0:0]        resp_dout;
  logic [RCW-1:0]    resp_cnt;
  logic              resp_pop;

  arb_fifo #(.WIDTH(REQ_W), .DEPTH(PEND_DEPTH)) u_pend (
    .clk(clk), .rst(rst), .push(any_gnt), .din({win_src, win_type, win_ent}),
    .pop(pend_pop), .dout(pend_dout), .count(pend_cnt));

  arb_fifo #(.WIDTH(DATA_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .push(wd_push), .din(wd_data),
    .pop(wbuf_pop), .dout(wbuf_dout), .count(wbuf_cnt));

  arb_fifo #(.WIDTH(1), .DEPTH(RESP_DEPTH)) u_resp (
    .clk(clk), .rst(rst), .push(cr_vld), .din(cr_hit),
    .pop(resp_pop), .dout(resp_dout), .count(resp_cnt));

  assign wd_full = (wbuf_cnt == OCC_W'(WBUF_DEPTH));

  // drain
  logic [1:0]        hd_src;
  logic              hd_type;
  logic [ENT_W-1:0]  hd_ent;
  logic              can_go, wr_go, rd_go, issue;

  assign {hd_src, hd_type, hd_ent} = pend_dout;
  assign can_go   = !pend_empty && !pd_w;
  assign wr_go    = can_go && hd_type && (wbuf_cnt != '0);
  assign rd_go    = can_go && !hd_type && (resp_cnt != '0);
  assign pend_pop = wr_go | rd_go;
  assign wbuf_pop = wr_go;
  assign resp_pop = rd_go;
  assign issue    = wr_go | (rd_go && !resp_dout[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_vld   <= 1'b0;
      mem_src   <= '0;
      mem_type  <= 1'b0;
      mem_addr  <= '0;
      mem_tag   <= '0;
      mem_wdata <= '0;
    end else begin
      mem_vld <= issue;
      if (issue) begin
        mem_src   <= hd_src;
        mem_type  <= hd_type;
        mem_addr  <= hd_ent[ENT_W-1:TAG_W];
        mem_tag   <= hd_ent[TAG_W-1:0];
        mem_wdata <= wr_go ? wbuf_dout : '0;
      end
    end
  end

  // R9
  mem_awake_chk: assert property (@(posedge clk) disable iff (rst)
    mem_vld |-> !$past(mem_pd));
endmodule

// File: tb/mem_pwr_arb_tb_top.sv
module mem_pwr_arb_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        mc_push, pf_push, fl_push, wd_push, cr_vld, cr_hit, mc_urgent;
  logic [39:0] mc_addr, pf_addr, fl_addr;
  logic [3:0]  mc_tag, pf_tag;
  logic [31:0] wd_data;
  logic [3:0]  cfg_rd_max, cfg_wr_max, cfg_wm_hi, cfg_wm_lo;
  logic [15:0] cfg_idle;
  logic        mc_full, pf_full, fl_full, wd_full;
  logic        snp_vld, snp_type, mem_vld, mem_type, mem_pd, fl_urgent;
  logic [1:0]  snp_src, mem_src;
  logic [39:0] snp_addr, mem_addr;
  logic [3:0]  snp_tag, mem_tag;
  logic [31:0] mem_wdata;

  int checks = 0;
  int errors = 0;
  int snp_n = 0;
  int mem_n = 0;
  logic [1:0]  s_src [32];
  logic        s_typ [32];
  logic [39:0] s_adr [32];
  logic [3:0]  s_tag [32];
  logic [1:0]  m_src [32];
  logic        m_typ [32];
  logic [39:0] m_adr [32];
  logic [3:0]  m_tag [32];
  logic [31:0] m_dat [32];

  always #10 clk = ~clk;

  mem_pwr_arb dut_i (
    .clk(clk), .rst(rst),
    .mc_push(mc_push), .mc_addr(mc_addr), .mc_tag(mc_tag), .mc_full(mc_full),
    .mc_urgent(mc_urgent),
    .pf_push(pf_push), .pf_addr(pf_addr), .pf_tag(pf_tag), .pf_full(pf_full),
    .fl_push(fl_push), .fl_addr(fl_addr), .fl_full(fl_full),
    .wd_push(wd_push), .wd_data(wd_data), .wd_full(wd_full),
    .cr_vld(cr_vld), .cr_hit(cr_hit),
    .cfg_rd_max(cfg_rd_max), .cfg_wr_max(cfg_wr_max),
    .cfg_wm_hi(cfg_wm_hi), .cfg_wm_lo(cfg_wm_lo), .cfg_idle(cfg_idle),
    .snp_vld(snp_vld), .snp_src(snp_src), .snp_type(snp_type),
    .snp_addr(snp_addr), .snp_tag(snp_tag),
    .mem_vld(mem_vld), .mem_src(mem_src), .mem_type(mem_type),
    .mem_addr(mem_addr), .mem_tag(mem_tag), .mem_wdata(mem_wdata),
    .mem_pd(mem_pd), .fl_urgent(fl_urgent));

  always @(negedge clk) begin
    if (!rst) begin
      if (snp_vld && snp_n < 32) begin
        s_src[snp_n] = snp_src; s_typ[snp_n] = snp_type;
        s_adr[snp_n] = snp_addr; s_tag[snp_n] = snp_tag;
        snp_n++;
      end
      if (mem_vld && mem_n < 32) begin
        m_src[mem_n] = mem_src; m_typ[mem_n] = mem_type; m_adr[mem_n] = mem_addr;
        m_tag[mem_n] = mem_tag; m_dat[mem_n] = mem_wdata;
        mem_n++;
      end
    end
  end

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    mc_push = 0; pf_push = 0; fl_push = 0; wd_push = 0; cr_vld = 0; cr_hit = 0;
    mc_urgent = 0; mc_addr = '0; pf_addr = '0; fl_addr = '0; mc_tag = '0; pf_tag = '0;
    wd_data = '0; cfg_rd_max = 4'd2; cfg_wr_max = 4'd1; cfg_wm_hi = 4'd2;
    cfg_wm_lo = 4'd1; cfg_idle = 16'd1000;
    repeat (3) @(negedge clk);
    snp_n = 0; mem_n = 0;
    rst = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic push_mc(input logic [39:0] a, input logic [3:0] t);
    @(negedge clk); mc_push = 1; mc_addr = a; mc_tag = t;
    @(negedge clk); mc_push = 0;
  endtask
  task automatic push_pf(input logic [39:0] a, input logic [3:0] t);
    @(negedge clk); pf_push = 1; pf_addr = a; pf_tag = t;
    @(negedge clk); pf_push = 0;
  endtask
  task automatic push_fl(input logic [39:0] a);
    @(negedge clk); fl_push = 1; fl_addr = a;
    @(negedge clk); fl_push = 0;
  endtask
  task automatic push_wd(input logic [31:0] d);
    @(negedge clk); wd_push = 1; wd_data = d;
    @(negedge clk); wd_push = 0;
  endtask
  task automatic cache_ans(input logic hit);
    @(negedge clk); cr_vld = 1; cr_hit = hit;
    @(negedge clk); cr_vld = 0;
  endtask
  task automatic wake();
    @(negedge clk); mc_urgent = 1;
    @(negedge clk); mc_urgent = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 mem_pd", mem_pd, 1);
    check("R1 snp_vld", snp_vld, 0);
    check("R1 mem_vld", mem_vld, 0);
    check("R1 fl_urgent", fl_urgent, 0);
    wait_cyc(6);
    check("R1 no grant when idle", snp_n, 0);
  endtask

  task automatic t_snoop_asleep();
    do_reset();
    push_mc(40'h12_3456_789A, 4'd5);
    @(negedge clk); #1;
    check("R6 snoop one cycle after grant", snp_vld, 1);
    check("R6 snoop src", snp_src, 1);
    check("R6 snoop type", snp_type, 0);
    check("R6 snoop addr", snp_addr, 40'h12_3456_789A);
    check("R6 snoop tag", snp_tag, 5);
    cache_ans(1'b0);
    wait_cyc(5);
    check("R9 no memory request while asleep", mem_n, 0);
    check("R9 still asleep", mem_pd, 1);
    wake();
    wait_cyc(4);
    check("R8 miss issued", mem_n, 1);
    check("R8 miss addr", m_adr[0], 40'h12_3456_789A);
    check("R8 miss src", m_src[0], 1);
    check("R8 miss tag", m_tag[0], 5);
    check("R8 miss type", m_typ[0], 0);
  endtask

  task automatic t_hit_drop();
    do_reset();
    wake();
    push_pf(40'h200, 4'd1);
    push_pf(40'h204, 4'd2);
    cache_ans(1'b1);
    cache_ans(1'b0);
    wait_cyc(6);
    check("R6 prefetch snoops", snp_n, 2);
    check("R6 prefetch src", s_src[0], 2);
    check("R8 hit dropped", mem_n, 1);
    check("R8 miss forwarded addr", m_adr[0], 40'h204);
    check("R8 miss forwarded src", m_src[0], 2);
  endtask

  task automatic t_write();
    do_reset();
    wake();
    push_fl(40'h300);
    wait_cyc(4);
    check("R6 filter snoop type", s_typ[0], 1);
    check("R6 filter tag zero", s_tag[0], 0);
    check("R6 filter src", s_src[0], 0);
    check("R7 write waits for data", mem_n, 0);
    push_wd(32'hDEAD_BEEF);
    wait_cyc(4);
    check("R7 write issued", mem_n, 1);
    check("R7 write type", m_typ[0], 1);
    check("R7 write data", m_dat[0], 32'hDEAD_BEEF);
    check("R7 write addr", m_adr[0], 40'h300);
    check("R7 write tag", m_tag[0], 0);
  endtask

  task automatic t_batch();
    do_reset();
    @(negedge clk);
    mc_push = 1; pf_push = 1; fl_push = 1;
    mc_addr = 40'hA0; pf_addr = 40'hB0; fl_addr = 40'hC0; mc_tag = 1; pf_tag = 2;
    @(negedge clk);
    mc_addr = 40'hA1; pf_addr = 40'hB1; fl_addr = 40'hC1;
    @(negedge clk);
    mc_push = 0; pf_push = 0; fl_push = 0;
    wait_cyc(10);
    check("R2 R3 grant count", snp_n, 6);
    check("R3 order 0", s_src[0], 1);
    check("R3 order 1", s_src[1], 1);
    check("R3 order 2 switch to write", s_src[2], 0);
    check("R3 order 3 back to read", s_src[3], 2);
    check("R3 order 4", s_src[4], 2);
    check("R3 order 5", s_src[5], 0);
    check("R2 first filter addr", s_adr[2], 40'hC0);
  endtask

  task automatic t_urgency();
    do_reset();
    push_wd(32'h1);
    push_wd(32'h2);
    wait_cyc(3);
    check("R4 at high mark not urgent", fl_urgent, 0);
    push_wd(32'h3);
    wait_cyc(3);
    check("R4 above high mark urgent", fl_urgent, 1);
    @(negedge clk);
    mc_push = 1; fl_push = 1; mc_addr = 40'h500; fl_addr = 40'h600; mc_tag = 3;
    @(negedge clk);
    mc_push = 0; fl_push = 0;
    wait_cyc(6);
    check("R2 urgent filter beats read mode", s_src[0], 0);
    check("R2 then reader", s_src[1], 1);
    check("R4 holds between marks", fl_urgent, 1);
    cache_ans(1'b1);
    push_fl(40'h610);
    wait_cyc(5);
    check("R4 occupancy one still urgent", fl_urgent, 1);
    push_fl(40'h620);
    wait_cyc(5);
    check("R4 below low mark clears", fl_urgent, 0);
    check("R7 three writes carried data", mem_n, 3);
    check("R7 first buffered quad", m_dat[0], 32'h1);
  endtask

  task automatic t_mc_urgent();
    do_reset();
    push_wd(32'h1); push_wd(32'h2); push_wd(32'h3);
    wait_cyc(3);
    @(negedge clk);
    mc_urgent = 1; mc_push = 1; fl_push = 1; mc_addr = 40'h700; fl_addr = 40'h800;
    @(negedge clk);
    mc_push = 0; fl_push = 0;
    @(negedge clk);
    mc_urgent = 0;
    wait_cyc(4);
    check("R2 urgent reader beats urgent filter", s_src[0], 1);
  endtask

  task automatic t_power();
    do_reset();
    cfg_idle = 16'd5;
    #1;
    check("R5 asleep before urgency", mem_pd, 1);
    @(negedge clk); mc_urgent = 1;
    @(negedge clk); mc_urgent = 0; #1;
    check("R5 awake after urgency", mem_pd, 0);
    wait_cyc(4);
    check("R5 awake during countdown", mem_pd, 0);
    wait_cyc(1);
    check("R5 asleep after idle count", mem_pd, 1);
  endtask

  task automatic t_full();
    do_reset();
    @(negedge clk);
    mc_push = 1; pf_push = 1; fl_push = 1;
    for (int i = 0; i < 4; i++) begin
      mc_addr = 40'h1000 + 40'(i); pf_addr = 40'h2000 + 40'(i); fl_addr = 40'h3000 + 40'(i);
      @(negedge clk);
    end
    mc_push = 0; pf_push = 0; fl_push = 0;
    wait_cyc(20);
    check("R10 grants stop at full pending", snp_n, 8);
    cache_ans(1'b0);
    wake();
    wait_cyc(10);
    check("R10 one slot one grant", snp_n, 9);
    check("R8 one miss drained", mem_n, 1);
  endtask

  initial begin
    rst = 1'b1;
    t_reset();
    t_snoop_asleep();
    t_hit_drop();
    t_write();
    t_batch();
    t_urgency();
    t_mc_urgent();
    t_power();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule